// File: doc/BRIEF.md
# Shift, Rotate and Single-Bit Operation Unit

This block is the combinational datapath for the extended shift, rotate and single-bit instruction group of an 8-bit processor. The sequencer gives it an operand byte, the current flags byte, a two-bit group code, a three-bit field and a short-form select. In the same cycle it returns the result byte, a writeback enable, the new flags byte and an illegal-operation indication. Operand fetch, indexed addressing and the nibble exchange between memory and accumulator are handled elsewhere.

The group code selects one of four groups: shifts and rotates, bit test, bit clear and bit set. In the shift group the field names the sub-operation. In the three bit groups the field is the index of the bit. The short-form select marks the accumulator-only rotate encodings. These compute the same result as the full forms but change only the half-carry, subtract and carry flags.

Top module: `rotbit_unit`

## Requirements
- R1: Group code 00 is shift/rotate, 01 is bit test, 10 is bit clear and 11 is bit set. Writeback enable is 1 for bit clear, bit set and every legal shift sub-operation. It is 0 for bit test.
- R2: Sub-operation 000 rotates left circularly: result is {op[6:0],op[7]} and carry-out is op[7]. Sub-operation 001 rotates right circularly: result is {op[0],op[7:1]} and carry-out is op[0].
- R3: Sub-operation 010 rotates left through carry: result is {op[6:0],cin} and carry-out is op[7]. Sub-operation 011 rotates right through carry: result is {cin,op[7:1]} and carry-out is op[0]. The incoming carry cin is bit 0 of the flags input.
- R4: Sub-operation 100 shifts left and fills bit 0 with 0. Sub-operation 101 shifts right and keeps bit 7. Sub-operation 111 shifts right and fills bit 7 with 0. For a left shift the carry-out is op[7]; for a right shift it is op[0].
- R5: The flags byte holds S at bit 7, Z at bit 6, H at bit 4, P/V at bit 2, N at bit 1 and C at bit 0. Bits 5 and 3 are copied from the flags input in every case. In a full-form shift or rotate, S is result bit 7 and Z is 1 when the result is zero. P/V is 1 when the result has an even number of ones. H and N are 0 and C is the carry-out.
- R6: With the short-form select at 1 in the shift group, H and N become 0 and C becomes the carry-out. S, Z and P/V keep their input values, and the result is the same as the full form.
- R7: Bit test sets Z to 1 when the selected bit is 0, sets H to 1 and N to 0, and keeps C. The result output equals the operand.
- R8: In bit test, S equals the tested bit when the index is 7 and is 0 for any other index. P/V equals the new Z.
- R9: Bit clear and bit set change only the indexed bit of the operand, to 0 and 1 respectively. The flags output equals the flags input.
- R10: Shift sub-operation 110 is illegal. The result is the operand, writeback enable is 0, the flags output equals the flags input and the illegal output is 1. The illegal output is 0 for every other combination.
- R11: The short-form select has no effect outside the shift group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 8 | Current flags byte; bit 0 is the incoming carry |
| group_i | input | 2 | Operation group code |
| sel_i | input | 3 | Shift sub-operation or bit index |
| acc_form_i | input | 1 | Short accumulator-only rotate form |
| result_o | output | 8 | Result byte |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 8 | New flags byte |
| illegal_o | output | 1 | Undefined shift sub-operation |

## Verification
Two things depend on the incoming carry at once. It enters the result of a through-carry rotate, and it must survive untouched in the C bit during bit test, bit clear and bit set. The short-form select also decides, in the same evaluation, whether S, Z and P/V come from the new result or pass through from the input. The bench sweeps every operand under every group, field and short-form setting, with several flags bytes that have the carry both set and clear and that have the otherwise-unused bits 5 and 3 set. Each output is compared against a behavioural model, so any leak between the computed flags and the preserved flags shows up.

// File: rtl/rotbit_pkg.sv
package rotbit_pkg;
  // Flag byte bit positions (decoded by the surrounding core)
  localparam int FLG_C  = 0;
  localparam int FLG_N  = 1;
  localparam int FLG_PV = 2;
  localparam int FLG_H  = 4;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;
  localparam int FLG_W  = 8;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SETB  = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SH_RLC = 3'b000,
    SH_RRC = 3'b001,
    SH_RL  = 3'b010,
    SH_RR  = 3'b011,
    SH_SLA = 3'b100,
    SH_SRA = 3'b101,
    SH_RSV = 3'b110,
    SH_SRL = 3'b111
  } shop_e;
endpackage

// File: rtl/rotbit_shift.sv
module rotbit_shift
  import rotbit_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd_i,
  input  logic         cin_i,
  input  shop_e        op_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         legal_o
);

  logic fill_lo;
  logic fill_hi;
  logic go_left;

  // select the bit entering the vacated end
  always_comb begin
    fill_lo = 1'b0;
    fill_hi = 1'b0;
    go_left = 1'b0;
    legal_o = 1'b1;
    unique case (op_i)
      SH_RLC: begin go_left = 1'b1; fill_lo = opnd_i[W-1]; end
      SH_RRC: fill_hi = opnd_i[0];
      SH_RL:  begin go_left = 1'b1; fill_lo = cin_i; end
      SH_RR:  fill_hi = cin_i;
      SH_SLA: go_left = 1'b1;
      SH_SRA: fill_hi = opnd_i[W-1];
      SH_SRL: fill_hi = 1'b0;
      default: legal_o = 1'b0;
    endcase
  end

  always_comb begin
    if (!legal_o) begin
      res_o  = opnd_i;
      cout_o = cin_i;
    end else if (go_left) begin
      res_o  = {opnd_i[W-2:0], fill_lo};
      cout_o = opnd_i[W-1];
    end else begin
      res_o  = {fill_hi, opnd_i[W-1:1]};
      cout_o = opnd_i[0];
    end
  end

  always_comb begin
    if (!$isunknown({opnd_i, cin_i, op_i})) begin
      a_r4_sra_keeps_sign: assert (op_i != SH_SRA || res_o[W-1] == opnd_i[W-1])
        else $error("R4 arithmetic shift lost sign");
      a_r2_rlc_wraps: assert (op_i != SH_RLC || res_o[0] == cout_o)
        else $error("R2 circular rotate carry mismatch");
    end
  end

endmodule

// File: rtl/rotbit_bitop.sv
module rotbit_bitop
  import rotbit_pkg::*;
#(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     opnd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_i,
  output logic [W-1:0]     res_o,
  output logic             bit_o
);

  logic [W-1:0] hit;

  for (genvar g = 0; g < W; g++) begin : g_lane
    assign hit[g]   = (idx_i == IDX_W'(g));
    assign res_o[g] = hit[g] ? set_i : opnd_i[g];
  end

  assign bit_o = |(hit & opnd_i);

  always_comb begin
    if (!$isunknown({opnd_i, idx_i, set_i})) begin
      a_r9_single_bit_change: assert ($countones(res_o ^ opnd_i) <= 1)
        else $error("R9 more than one bit changed");
    end
  end

endmodule

// File: rtl/rotbit_flags.sv
module rotbit_flags
  import rotbit_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [FLG_W-1:0] flags_i,
  input  grp_e             grp_i,
  input  logic             short_i,
  input  logic             legal_i,
  input  logic [W-1:0]     sh_res_i,
  input  logic             sh_cout_i,
  input  logic             tbit_i,
  input  logic             top_idx_i,
  output logic [FLG_W-1:0] flags_o
);

  logic zero_tst;

  assign zero_tst = ~tbit_i;

  always_comb begin
    flags_o = flags_i;
    unique case (grp_i)
      GRP_SHIFT: begin
        if (legal_i) begin
          flags_o[FLG_H] = 1'b0;
          flags_o[FLG_N] = 1'b0;
          flags_o[FLG_C] = sh_cout_i;
          if (!short_i) begin
            flags_o[FLG_S]  = sh_res_i[W-1];
            flags_o[FLG_Z]  = (sh_res_i == '0);
            flags_o[FLG_PV] = ~^sh_res_i;
          end
        end
      end
      GRP_TEST: begin
        flags_o[FLG_Z]  = zero_tst;
        flags_o[FLG_H]  = 1'b1;
        flags_o[FLG_N]  = 1'b0;
        flags_o[FLG_S]  = top_idx_i & tbit_i;
        flags_o[FLG_PV] = zero_tst;
      end
      default: flags_o = flags_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({flags_i, grp_i, short_i, legal_i, sh_res_i, sh_cout_i, tbit_i, top_idx_i})) begin
      a_r6_short_keeps_szp: assert (!(grp_i == GRP_SHIFT && short_i) ||
          (flags_o[FLG_S] == flags_i[FLG_S] && flags_o[FLG_Z] == flags_i[FLG_Z] &&
           flags_o[FLG_PV] == flags_i[FLG_PV]))
        else $error("R6 short form touched S/Z/PV");
      a_r5_spare_bits_kept: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3])
        else $error("R5 spare flag bits changed");
      a_r7_test_keeps_carry: assert (grp_i != GRP_TEST || flags_o[FLG_C] == flags_i[FLG_C])
        else $error("R7 bit test changed carry");
    end
  end

endmodule

// File: rtl/rotbit_unit.sv
module rotbit_unit
  import rotbit_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [FLG_W-1:0]  flags_i,
  input  logic [1:0]        group_i,
  input  logic [IDX_W-1:0]  sel_i,
  input  logic              acc_form_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [FLG_W-1:0]  flags_o,
  output logic              illegal_o
);

  grp_e              grp;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cout;
  logic              sh_legal;
  logic [DATA_W-1:0] bo_res;
  logic              tbit;

  assign grp = grp_e'(group_i);

  rotbit_shift #(.W(DATA_W)) u_shift (
    .opnd_i  (opnd_i),
    .cin_i   (flags_i[FLG_C]),
    .op_i    (shop_e'(sel_i[2:0])),
    .res_o   (sh_res),
    .cout_o  (sh_cout),
    .legal_o (sh_legal)
  );

  rotbit_bitop #(.W(DATA_W)) u_bitop (
    .opnd_i (opnd_i),
    .idx_i  (sel_i),
    .set_i  (group_i[0]),
    .res_o  (bo_res),
    .bit_o  (tbit)
  );

  rotbit_flags #(.W(DATA_W)) u_flags (
    .flags_i   (flags_i),
    .grp_i     (grp),
    .short_i   (acc_form_i),
    .legal_i   (sh_legal),
    .sh_res_i  (sh_res),
    .sh_cout_i (sh_cout),
    .tbit_i    (tbit),
    .top_idx_i (sel_i == IDX_W'(DATA_W-1)),
    .flags_o   (flags_o)
  );

  always_comb begin
    unique case (grp)
      GRP_SHIFT: begin
        result_o  = sh_res;
        wr_en_o   = sh_legal;
        illegal_o = ~sh_legal;
      end
      GRP_TEST: begin
        result_o  = opnd_i;
        wr_en_o   = 1'b0;
        illegal_o = 1'b0;
      end
      default: begin
        result_o  = bo_res;
        wr_en_o   = 1'b1;
        illegal_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (!$isunknown({opnd_i, flags_i, group_i, sel_i, acc_form_i})) begin
      a_r1_test_no_write: assert (grp != GRP_TEST || !wr_en_o)
        else $error("R1 bit test wrote back");
      a_r9_bitop_flags_kept: assert (!group_i[1] || flags_o == flags_i)
        else $error("R9 bit clear/set changed flags");
      a_r10_illegal_inert: assert (!illegal_o ||
          (!wr_en_o && result_o == opnd_i && flags_o == flags_i))
        else $error("R10 illegal op had an effect");
    end
  end

endmodule

// File: tb/rotbit_unit_tb.sv
module rotbit_unit_tb;

  logic       clk;
  logic       rst_n;
  logic [7:0] opnd;
  logic [7:0] flg;
  logic [1:0] grp;
  logic [2:0] sel;
  logic       accf;
  logic [7:0] res;
  logic       wr;
  logic [7:0] fout;
  logic       ill;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done  = 0;

  rotbit_unit u_dut (
    .opnd_i     (opnd),
    .flags_i    (flg),
    .group_i    (grp),
    .sel_i      (sel),
    .acc_form_i (accf),
    .result_o   (res),
    .wr_en_o    (wr),
    .flags_o    (fout),
    .illegal_o  (ill)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 199000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<199000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic string tag_of(input int g, input int s, input int a);
    if (g == 1) return "R7/R8";
    if (g >= 2) return "R9";
    if (s == 6) return "R10";
    if (a == 1) return "R6";
    if (s <= 1) return "R2/R5";
    if (s <= 3) return "R3/R5";
    return "R4/R5";
  endfunction

  // behavioural reference: {illegal, wr, flags, result}
  function automatic logic [17:0] model(input int o, input int f, input int g,
                                        input int s, input int a);
    int r = o;
    int nf = f;
    int c = f % 2;
    int co = 0;
    int ones = 0;
    int il = 0;
    int w = 1;
    if (g == 0) begin
      case (s)
        0: begin co = o / 128; r = (o * 2) % 256 + co; end
        1: begin co = o % 2;   r = o / 2 + co * 128; end
        2: begin co = o / 128; r = (o * 2) % 256 + c; end
        3: begin co = o % 2;   r = o / 2 + c * 128; end
        4: begin co = o / 128; r = (o * 2) % 256; end
        5: begin co = o % 2;   r = o / 2 + (o / 128) * 128; end
        7: begin co = o % 2;   r = o / 2; end
        default: begin il = 1; w = 0; r = o; end
      endcase
      if (il == 0) begin
        nf = nf & ~(16 | 2 | 1);
        nf = nf | co;
        if (a == 0) begin
          for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
          nf = nf & ~(128 | 64 | 4);
          if (r >= 128) nf = nf | 128;
          if (r == 0) nf = nf | 64;
          if (ones % 2 == 0) nf = nf | 4;
        end
      end
    end else if (g == 1) begin
      int b = (o >> s) & 1;
      w = 0;
      nf = nf & ~(128 | 64 | 16 | 4 | 2);
      nf = nf | 16;
      if (b == 0) nf = nf | 64 | 4;
      if (s == 7 && b == 1) nf = nf | 128;
    end else if (g == 2) begin
      r = o & ~(1 << s);
    end else begin
      r = o | (1 << s);
    end
    return {il[0], w[0], nf[7:0], r[7:0]};
  endfunction

  task automatic check(input int g, input int s, input int a);
    logic [17:0] e;
    e = model(opnd, flg, g, s, a);
    total++;
    if ({ill, wr, fout, res} !== e) begin
      bad++;
      $display("FAIL %s R1 R11: op=%h f=%h g=%0d s=%0d a=%0d actual il=%b wr=%b f=%h r=%h expected il=%b wr=%b f=%h r=%h",
               tag_of(g, s, a), opnd, flg, g, s, a, ill, wr, fout, res,
               e[17], e[16], e[15:8], e[7:0]);
    end
  endtask

  initial begin
    int fpat [4] = '{8'h00, 8'hFF, 8'h29, 8'hD6};
    rst_n = 1'b0;
    opnd = 8'h00; flg = 8'h00; grp = 2'b00; sel = 3'b000; accf = 1'b0;
    @(negedge clk);
    // reset state: zero operand rotated circularly gives Z and even parity (R1, R5)
    total++;
    if (res !== 8'h00 || wr !== 1'b1 || fout !== 8'h44 || ill !== 1'b0) begin
      bad++;
      $display("FAIL R5 reset: actual r=%h wr=%b f=%h il=%b expected r=00 wr=1 f=44 il=0",
               res, wr, fout, ill);
    end
    @(posedge clk);
    rst_n = 1'b1;
    // full sweep: carry in/out and preserved flags meet in every group (R2 R3 R4 R6 R7 R8 R9 R10 R11)
    for (int fi = 0; fi < 4; fi++) begin
      for (int a = 0; a < 2; a++) begin
        for (int g = 0; g < 4; g++) begin
          for (int s = 0; s < 8; s++) begin
            for (int o = 0; o < 256; o++) begin
              @(posedge clk);
              #2;
              opnd = o[7:0]; flg = fpat[fi][7:0]; grp = g[1:0]; sel = s[2:0]; accf = a[0];
              @(negedge clk);
              check(g, s, a);
            end
          end
        end
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule